// File: doc/BRIEF.md
# Host-to-Slave Mailbox with Status Flags

This block is a one-byte mailbox in each direction between an external host processor and an on-chip slave processor. The host writes an inbound data byte that the slave reads. The slave writes an outbound data byte that the host reads. An 8-bit status byte can be read from both sides. It holds two buffer-full flags, a command/data marker and five bits whose meaning software chooses. The inbound-full flag is also the interrupt request to the slave.

The host side is a strobed I/O port. Host address bit 0 selects the data byte (0) or the status byte (1). Host address bit 2 is sampled on every inbound data write as the command/data marker. The slave side is a strobed register port with a one-bit address: 0 is the data byte and 1 is the status byte. Read data is combinational and is valid while the read strobe is high. Any flag that changes because of an access updates on the following rising clock edge.

Top module: `mbox_port`

## Requirements
- R1: After reset, every status bit is 0, both data bytes are 0, and `slvIrq` is 0.
- R2: A host write with `hostAddr[0]`=0 loads the inbound byte and sets status bit 1 (inbound full). The slave then reads that byte at `slvAddr`=0.
- R3: On every host write with `hostAddr[0]`=0, `hostAddr[2]` is copied into status bit 3 (1 = command, 0 = data).
- R4: A slave read at `slvAddr`=0 clears status bit 1. `slvIrq` equals status bit 1 at all times.
- R5: A slave write at `slvAddr`=0 loads the outbound byte and sets status bit 0 (outbound full). The host then reads that byte at `hostAddr[0]`=0.
- R6: A host read with `hostAddr[0]`=0 clears status bit 0.
- R7: A slave write at `slvAddr`=1 with data bit 0 equal to 0 clears status bit 0. With data bit 0 equal to 1, status bit 0 is unchanged.
- R8: A slave write at `slvAddr`=1 stores data bits 7..4 and 2 into the same status bits. It leaves status bits 3 and 1 unchanged.
- R9: A host write with `hostAddr[0]`=1 changes nothing.
- R10: When a set and a clear of the same flag fall in one cycle, the flag ends up set. This applies to inbound full (host data write with slave data read) and to outbound full (slave data write with host data read).
- R11: Status reads from either side, and slave status reads, change no flag and no data byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Host write strobe, one cycle per access |
| hostRd | input | 1 | Host read strobe, one cycle per access |
| hostAddr | input | 3 | Host address: bit 0 selects data/status, bit 2 gives command/data |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data (outbound byte or status) |
| slvWr | input | 1 | Slave write strobe |
| slvRd | input | 1 | Slave read strobe |
| slvAddr | input | 1 | Slave address: 0 data, 1 status |
| slvWdata | input | 8 | Slave write data |
| slvRdata | output | 8 | Slave read data (inbound byte or status) |
| slvIrq | output | 1 | Interrupt to the slave, high while the inbound byte is full |

## Verification
The bench tries host writes at all eight host addresses. This separates the select bit from the command/data bit, and it shows that the unused address bit and status-address writes have no effect. All 256 slave status-write values are applied, with the outbound flag sometimes preset and sometimes clear. These writes expose any error in the user-bit mask, in write protection of the read-only flags, or in the rule that bit 0 can only be cleared by writing 0. Concurrent set/clear pairs show which event has priority. Repeated status reads show that those reads have no side effects.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // Status bit positions; software on both sides decodes these.
  localparam int STS_W    = 8;
  localparam int OBF_BIT  = 0;
  localparam int IBF_BIT  = 1;
  localparam int CD_BIT   = 3;
  localparam logic [STS_W-1:0] USER_MASK = 8'hF4;

  // Strobes from the access decoder to the register datapath.
  typedef struct packed {
    logic inLoad;     // host writes inbound byte
    logic inTake;     // slave reads inbound byte
    logic cdIn;       // command/data value for inLoad
    logic outLoad;    // slave writes outbound byte
    logic outTake;    // host reads outbound byte
    logic userWr;     // slave writes status
    logic obfClr;     // slave status write with bit 0 = 0
    logic hostStsSel; // host read mux selects status
    logic slvStsSel;  // slave read mux selects status
  } mboxStrobeT;

endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int HA_W    = 3,
  parameter int SEL_BIT = 0,
  parameter int CD_SRC  = 2
) (
  input  logic            hostWr,
  input  logic            hostRd,
  input  logic [HA_W-1:0] hostAddr,
  input  logic            slvWr,
  input  logic            slvRd,
  input  logic            slvAddr,
  input  logic            slvObfBit,
  output mboxStrobeT      stb
);

  logic hostData;
  logic unusedHostAddr;

  assign hostData       = !hostAddr[SEL_BIT];
  assign unusedHostAddr = ^hostAddr;

  always_comb begin
    stb            = '0;
    stb.inLoad     = hostWr && hostData;
    stb.cdIn       = hostAddr[CD_SRC];
    stb.outTake    = hostRd && hostData;
    stb.hostStsSel = !hostData;
    stb.outLoad    = slvWr && !slvAddr;
    stb.inTake     = slvRd && !slvAddr;
    stb.userWr     = slvWr && slvAddr;
    stb.obfClr     = slvWr && slvAddr && !slvObfBit;
    stb.slvStsSel  = slvAddr;
  end

endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  mboxStrobeT        stb,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] slvWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic [DATA_W-1:0] slvRdata,
  output logic              inFull
);

  logic [DATA_W-1:0] inQ, outQ;
  logic [STS_W-1:0]  userQ, sts;
  logic              ibfQ, obfQ, cdQ;
  logic              ibfNext, obfNext;

  // Set wins over clear for both flags.
  always_comb begin
    ibfNext = ibfQ;
    if (stb.inTake)  ibfNext = 1'b0;
    if (stb.inLoad)  ibfNext = 1'b1;
    obfNext = obfQ;
    if (stb.outTake || stb.obfClr) obfNext = 1'b0;
    if (stb.outLoad) obfNext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inQ   <= '0;
      outQ  <= '0;
      userQ <= '0;
      ibfQ  <= 1'b0;
      obfQ  <= 1'b0;
      cdQ   <= 1'b0;
    end else begin
      ibfQ <= ibfNext;
      obfQ <= obfNext;
      if (stb.inLoad) begin
        inQ <= hostWdata;
        cdQ <= stb.cdIn;
      end
      if (stb.outLoad) outQ <= slvWdata;
      if (stb.userWr) userQ <= slvWdata[STS_W-1:0] & USER_MASK;
    end
  end

  always_comb begin
    sts          = userQ;
    sts[CD_BIT]  = cdQ;
    sts[IBF_BIT] = ibfQ;
    sts[OBF_BIT] = obfQ;
  end

  assign hostRdata = stb.hostStsSel ? DATA_W'(sts) : outQ;
  assign slvRdata  = stb.slvStsSel  ? DATA_W'(sts) : inQ;
  assign inFull    = ibfQ;

  // R2
  ibf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.inLoad |=> ibfQ && inQ == $past(hostWdata));
  // R3
  cd_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.inLoad |=> cdQ == $past(stb.cdIn));
  // R4
  ibf_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.inTake && !stb.inLoad |=> !ibfQ);
  // R5
  obf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.outLoad |=> obfQ && outQ == $past(slvWdata));
  // R6
  obf_host_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.outTake && !stb.outLoad |=> !obfQ);
  // R7
  obf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.outLoad && !stb.outTake && !stb.obfClr |=> $stable(obfQ));
  // R8
  cd_readonly_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.inLoad |=> $stable(cdQ) && $stable(inQ));
  // R11
  ibf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.inLoad && !stb.inTake |=> $stable(ibfQ));

endmodule

// File: rtl/mbox_port.sv
module mbox_port
  import mbox_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HA_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [HA_W-1:0]   hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  input  logic              slvWr,
  input  logic              slvRd,
  input  logic              slvAddr,
  input  logic [DATA_W-1:0] slvWdata,
  output logic [DATA_W-1:0] slvRdata,
  output logic              slvIrq
);

  mboxStrobeT stb;

  mbox_ctrl #(.HA_W(HA_W), .SEL_BIT(0), .CD_SRC(2)) i_ctrl (
    .hostWr    (hostWr),
    .hostRd    (hostRd),
    .hostAddr  (hostAddr),
    .slvWr     (slvWr),
    .slvRd     (slvRd),
    .slvAddr   (slvAddr),
    .slvObfBit (slvWdata[OBF_BIT]),
    .stb       (stb)
  );

  mbox_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .hostWdata (hostWdata),
    .slvWdata  (slvWdata),
    .hostRdata (hostRdata),
    .slvRdata  (slvRdata),
    .inFull    (slvIrq)
  );

endmodule

// File: tb/test_mbox_port.sv
module test_mbox_port;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostWr = 1'b0, hostRd = 1'b0;
  logic [2:0] hostAddr = '0;
  logic [7:0] hostWdata = '0, hostRdata;
  logic       slvWr = 1'b0, slvRd = 1'b0, slvAddr = 1'b0;
  logic [7:0] slvWdata = '0, slvRdata;
  logic       slvIrq;

  int errors = 0;
  int checks = 0;
  logic [7:0] expIn = '0, expOut = '0, expSts = '0;

  always #4 clk = ~clk;

  mbox_port i_mbox_port (
    .clk(clk), .rstN(rstN),
    .hostWr(hostWr), .hostRd(hostRd), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata),
    .slvWr(slvWr), .slvRd(slvRd), .slvAddr(slvAddr),
    .slvWdata(slvWdata), .slvRdata(slvRdata), .slvIrq(slvIrq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); hostWr = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk); hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); hostRd = 1'b1; hostAddr = a;
    #1 d = hostRdata;
    @(negedge clk); hostRd = 1'b0;
  endtask

  task automatic slvWrite(input logic a, input logic [7:0] d);
    @(negedge clk); slvWr = 1'b1; slvAddr = a; slvWdata = d;
    @(negedge clk); slvWr = 1'b0;
  endtask

  task automatic slvRead(input logic a, output logic [7:0] d);
    @(negedge clk); slvRd = 1'b1; slvAddr = a;
    #1 d = slvRdata;
    @(negedge clk); slvRd = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    hostRead(3'b001, rd); chk("R1 status", rd, 8'h00);
    chk("R1 irq", {7'b0, slvIrq}, 8'h00);
    slvRead(1'b0, rd); chk("R1 inbound byte", rd, 8'h00);
    hostRead(3'b000, rd); chk("R1 outbound byte", rd, 8'h00);

    // R2 R3 R4 R9: host writes at every host address
    for (int a = 0; a < 8; a++) begin
      logic [7:0] d;
      d = 8'h3C ^ 8'(a * 37);
      hostWrite(3'(a), d);
      if (a % 2 == 0) begin
        expIn = d;
        expSts[1] = 1'b1;
        expSts[3] = (a >= 4);
      end
      chk("R4 irq follows inbound full", {7'b0, slvIrq}, {7'b0, expSts[1]});
      // R11: repeated status reads keep flags
      hostRead(3'b001, rd); chk("R2/R3/R9 status via host", rd, expSts);
      slvRead(1'b1, rd); chk("R11 status via slave", rd, expSts);
      slvRead(1'b0, rd); chk("R2 inbound byte", rd, expIn);
      expSts[1] = 1'b0;
      chk("R4 irq cleared by slave read", {7'b0, slvIrq}, 8'h00);
      hostRead(3'b001, rd); chk("R4 status after slave read", rd, expSts);
    end

    // R5 R6 outbound path
    for (int k = 0; k < 4; k++) begin
      logic [7:0] d;
      d = 8'hA5 + 8'(k * 29);
      slvWrite(1'b0, d); expOut = d; expSts[0] = 1'b1;
      slvRead(1'b1, rd); chk("R5 outbound full set", rd, expSts);
      hostRead(3'b100, rd); chk("R5 outbound byte", rd, expOut);
      expSts[0] = 1'b0;
      hostRead(3'b001, rd); chk("R6 host read clears outbound full", rd, expSts);
    end

    // R7 R8: every slave status write value
    for (int v = 0; v < 256; v++) begin
      if (v % 3 == 0) begin
        slvWrite(1'b0, 8'(v)); expOut = 8'(v); expSts[0] = 1'b1;
      end
      slvWrite(1'b1, 8'(v));
      expSts = (expSts & 8'h0B) | (8'(v) & 8'hF4);
      if (v % 2 == 0) expSts[0] = 1'b0;
      hostRead(3'b001, rd); chk("R7/R8 status after slave write", rd, expSts);
    end
    hostRead(3'b000, rd); chk("R5 outbound byte after sweep", rd, expOut);
    expSts[0] = 1'b0;

    // R10 inbound: host data write with slave data read in one cycle
    @(negedge clk);
    hostWr = 1'b1; hostAddr = 3'b100; hostWdata = 8'h5A;
    slvRd = 1'b1; slvAddr = 1'b0;
    @(negedge clk);
    hostWr = 1'b0; slvRd = 1'b0;
    expIn = 8'h5A; expSts[1] = 1'b1; expSts[3] = 1'b1;
    chk("R10 inbound set wins irq", {7'b0, slvIrq}, 8'h01);
    hostRead(3'b001, rd); chk("R10 inbound set wins status", rd, expSts);

    // R10 outbound: slave data write with host data read in one cycle
    @(negedge clk);
    slvWr = 1'b1; slvAddr = 1'b0; slvWdata = 8'hC3;
    hostRd = 1'b1; hostAddr = 3'b000;
    @(negedge clk);
    slvWr = 1'b0; hostRd = 1'b0;
    expOut = 8'hC3; expSts[0] = 1'b1;
    slvRead(1'b1, rd); chk("R10 outbound set wins status", rd, expSts);
    hostRead(3'b000, rd); chk("R10 outbound byte", rd, expOut);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule